// File: doc/BRIEF.md
# Clock Loss Detector with Validation

The block watches an incoming clock from a faster local reference clock. Two flops bring the input into the reference domain. A shift register holds the latest synchronized samples. When the input has stopped toggling, the samples in the register all read high or all read low, and the block raises a loss-of-signal alarm. The alarm is sticky. It clears only after the input has been free of loss events for a whole validation window. Any loss event inside the window sends the count back to zero.

A pin selects a short or a long window. Both lengths are parameters in reference-clock cycles, so a bench can use small values. Power-up and every rising edge of the active-low reset/calibrate input force the alarm high. After such a trigger the alarm also waits for a calibration-done flag from the PLL control logic, even when the window has already run out. The cycle in which the alarm clears carries a single-cycle valid-input strobe, which a downstream sequencer uses to start locking.

Top module: `clk_loss_monitor`

## Requirements
- R1: A loss event is flagged when the last four synchronized samples of `clk_in` are all 1 or all 0. A high or low run of three reference cycles flags no loss.
- R2: A loss event while the alarm is low drives `los_alarm` high no more than 8 reference cycles after `clk_in` stops toggling.
- R3: With `win_long` = 0 the alarm stays high until SHORT_WIN consecutive loss-free reference cycles have passed, and then it clears.
- R4: With `win_long` = 1 the window is LONG_WIN cycles instead of SHORT_WIN.
- R5: A loss event during a running window keeps the alarm high and restarts the window from zero.
- R6: While `rst_cal_n` is low, `los_alarm` reads 1 and `valid_pulse` reads 0. After every release of `rst_cal_n` the alarm is still high.
- R7: After `rst_cal_n` is released, the alarm does not clear before `cal_done` has been seen high, even when the window has completed.
- R8: `valid_pulse` is high for exactly one cycle, and only in the first cycle in which `los_alarm` reads 0 after being 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Local reference clock, faster than the monitored clock |
| rst_cal_n | input | 1 | Active-low reset; its release starts a calibration cycle |
| clk_in | input | 1 | Monitored clock, asynchronous to ref_clk |
| win_long | input | 1 | Window select: 0 for SHORT_WIN, 1 for LONG_WIN |
| cal_done | input | 1 | High once PLL self-calibration has finished |
| los_alarm | output | 1 | Sticky loss-of-signal alarm |
| valid_pulse | output | 1 | One-cycle strobe when the alarm clears |

## Verification
The hardest case to reach from the ports is a window restart. The input must toggle cleanly for part of a window, then stall long enough to fill the sample register, and then resume. The alarm must then still be high past the point where it would have cleared without the stall. The bench generates the monitored clock from the reference clock at a chosen half-period, with zero meaning stalled. Because of this, run lengths of three and four samples, and the stall length, are exact in cycles. The calibration hold is reached by releasing reset with `cal_done` low and running clean input well past the window.

// File: rtl/clm_pkg.sv
package clm_pkg;
    localparam int unsigned SYNC_STAGES = 2;
    localparam int unsigned RUN_LEN     = 4;

    typedef struct packed {
        logic alarm;
        logic cal_pend;
        logic valid;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{alarm: 1'b1, cal_pend: 1'b1, valid: 1'b0};
endpackage

// File: rtl/clm_sync.sv
module clm_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/clm_run_detect.sv
module clm_run_detect #(
    parameter int unsigned RUN_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp,
    output logic loss
);
    logic [RUN_LEN-1:0] hist_d, hist_q;

    always_comb begin
        hist_d = {hist_q[RUN_LEN-2:0], smp};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

    // a run of RUN_LEN equal samples means the input did not toggle
    assign loss = (&hist_q) | ~(|hist_q);
endmodule

// File: rtl/clm_valid_timer.sv
module clm_valid_timer #(
    parameter int unsigned SHORT_WIN = 16,
    parameter int unsigned LONG_WIN  = 64,
    localparam int unsigned CW       = $clog2(LONG_WIN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          win_long,
    output logic          done,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] LIM_S = CW'(SHORT_WIN);
    localparam logic [CW-1:0] LIM_L = CW'(LONG_WIN);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] limit;

    always_comb begin
        limit = win_long ? LIM_L : LIM_S;
        done  = (cnt_q >= limit);
        if (clear)      cnt_d = '0;
        else if (!done) cnt_d = cnt_q + 1'b1;
        else            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/clk_loss_monitor.sv
module clk_loss_monitor #(
    parameter int unsigned SHORT_WIN = 100000,
    parameter int unsigned LONG_WIN  = 10000000,
    localparam int unsigned CW       = $clog2(LONG_WIN + 1)
) (
    input  logic ref_clk,
    input  logic rst_cal_n,
    input  logic clk_in,
    input  logic win_long,
    input  logic cal_done,
    output logic los_alarm,
    output logic valid_pulse
);
    import clm_pkg::*;

    logic          smp_w;
    logic          loss_w;
    logic          done_w;
    logic [CW-1:0] cnt_w;
    logic          release_w;
    ctl_t          ctl_d, ctl_q;

    clm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(ref_clk), .rst_n(rst_cal_n), .d(clk_in), .q(smp_w)
    );

    clm_run_detect #(.RUN_LEN(RUN_LEN)) u_run (
        .clk(ref_clk), .rst_n(rst_cal_n), .smp(smp_w), .loss(loss_w)
    );

    clm_valid_timer #(.SHORT_WIN(SHORT_WIN), .LONG_WIN(LONG_WIN)) u_timer (
        .clk(ref_clk), .rst_n(rst_cal_n), .clear(loss_w | ~ctl_q.alarm),
        .win_long(win_long), .done(done_w), .cnt(cnt_w)
    );

    always_comb begin
        release_w      = ctl_q.alarm & done_w & ~loss_w & ~ctl_q.cal_pend;
        ctl_d          = ctl_q;
        ctl_d.cal_pend = ctl_q.cal_pend & ~cal_done;
        ctl_d.valid    = release_w;
        if (loss_w)         ctl_d.alarm = 1'b1;
        else if (release_w) ctl_d.alarm = 1'b0;
    end

    always_ff @(posedge ref_clk or negedge rst_cal_n) begin
        if (!rst_cal_n) ctl_q <= CTL_RESET;
        else            ctl_q <= ctl_d;
    end

    assign los_alarm   = ctl_q.alarm;
    assign valid_pulse = ctl_q.valid;
endmodule

// File: rtl/clm_checker.sv
module clm_checker #(
    parameter int unsigned LONG_WIN = 64,
    parameter int unsigned CW       = 7
) (
    input logic          ref_clk,
    input logic          rst_cal_n,
    input logic          los_alarm,
    input logic          valid_pulse,
    input logic          det_loss,
    input logic          cal_pend,
    input logic [CW-1:0] val_cnt
);
    a_r2_loss_sets_alarm: assert property (@(posedge ref_clk) disable iff (!rst_cal_n)
        det_loss |=> los_alarm);

    a_r5_release_needs_clean: assert property (@(posedge ref_clk) disable iff (!rst_cal_n)
        $fell(los_alarm) |-> !$past(det_loss));

    a_r7_hold_during_cal: assert property (@(posedge ref_clk) disable iff (!rst_cal_n)
        cal_pend |-> los_alarm);

    a_r8_pulse_on_fall: assert property (@(posedge ref_clk) disable iff (!rst_cal_n)
        $fell(los_alarm) |-> valid_pulse);

    a_r8_pulse_only_on_fall: assert property (@(posedge ref_clk) disable iff (!rst_cal_n)
        valid_pulse |-> $fell(los_alarm));

    a_r8_pulse_single: assert property (@(posedge ref_clk) disable iff (!rst_cal_n)
        valid_pulse |=> !valid_pulse);

    a_r4_count_bounded: assert property (@(posedge ref_clk) disable iff (!rst_cal_n)
        val_cnt <= CW'(LONG_WIN));
endmodule

bind clk_loss_monitor clm_checker #(.LONG_WIN(LONG_WIN), .CW(CW)) u_chk (
    .ref_clk(ref_clk), .rst_cal_n(rst_cal_n), .los_alarm(los_alarm),
    .valid_pulse(valid_pulse), .det_loss(loss_w), .cal_pend(ctl_q.cal_pend),
    .val_cnt(cnt_w)
);

// File: tb/sim_clk_loss_monitor.sv
module sim_clk_loss_monitor;
    localparam int unsigned SW = 40;
    localparam int unsigned LW = 120;

    logic ref_clk = 1'b0;
    logic rst_cal_n = 1'b0;
    logic clk_in = 1'b0;
    logic win_long = 1'b0;
    logic cal_done = 1'b1;
    logic los_alarm, valid_pulse;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int pulse_bad = 0;
    int ph = 0;
    logic prev_alarm = 1'b1;

    always #5 ref_clk = ~ref_clk;

    clk_loss_monitor #(.SHORT_WIN(SW), .LONG_WIN(LW)) u0 (
        .ref_clk(ref_clk), .rst_cal_n(rst_cal_n), .clk_in(clk_in),
        .win_long(win_long), .cal_done(cal_done),
        .los_alarm(los_alarm), .valid_pulse(valid_pulse)
    );

    // R8 monitor: pulse must sit exactly on the 1->0 edge of the alarm
    always @(negedge ref_clk) begin
        if (rst_cal_n) begin
            if (valid_pulse !== (prev_alarm && !los_alarm)) pulse_bad++;
            if (valid_pulse === 1'b1) pulses++;
        end
        prev_alarm = rst_cal_n ? los_alarm : 1'b1;
    end

    typedef struct packed {
        logic [3:0] hp;   // half period in ref cycles, 0 = stalled
        logic       wl;
        logic [9:0] n;
        logic       exp;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{hp: 4'd2, wl: 1'b0, n: 10'd20, exp: 1'b1},  // R3 window still running
        '{hp: 4'd2, wl: 1'b0, n: 10'd40, exp: 1'b0},  // R3 window complete
        '{hp: 4'd3, wl: 1'b0, n: 10'd30, exp: 1'b0},  // R1 runs of three
        '{hp: 4'd0, wl: 1'b0, n: 10'd10, exp: 1'b1},  // R2 stalled input
        '{hp: 4'd2, wl: 1'b1, n: 10'd80, exp: 1'b1},  // R4 long window running
        '{hp: 4'd2, wl: 1'b1, n: 10'd70, exp: 1'b0},  // R4 long window complete
        '{hp: 4'd4, wl: 1'b0, n: 10'd20, exp: 1'b1},  // R1 runs of four
        '{hp: 4'd1, wl: 1'b0, n: 10'd60, exp: 1'b0}   // R3 fast toggle
    };

    task automatic chk(input logic got, input logic exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic run(input int hp, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge ref_clk);
            if (hp != 0) begin
                ph++;
                if (ph >= hp) begin
                    clk_in = ~clk_in;
                    ph = 0;
                end
            end
        end
        #1;
    endtask

    task automatic do_reset(input logic cd);
        @(negedge ref_clk);
        cal_done = cd;
        rst_cal_n = 1'b0;
        #1;
        chk(los_alarm, 1'b1, "R6", "alarm in reset");
        chk(valid_pulse, 1'b0, "R6", "strobe in reset");
        run(0, 3);
        @(negedge ref_clk);
        rst_cal_n = 1'b1;
        #1;
        chk(los_alarm, 1'b1, "R6", "alarm after reset release");
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset(1'b1);

        foreach (VEC[k]) begin
            win_long = VEC[k].wl;
            run(int'(VEC[k].hp), int'(VEC[k].n));
            chk(los_alarm, VEC[k].exp, "table", $sformatf("vector %0d", k));
        end
        chk(pulses == 3, 1'b1, "R8", "strobe count after table");

        // R5: a stall inside the window restarts it
        win_long = 1'b0;
        run(0, 10);
        chk(los_alarm, 1'b1, "R2", "stall before restart test");
        run(2, 25);
        run(0, 6);
        run(2, 30);
        chk(los_alarm, 1'b1, "R5", "window restarted after stall");
        run(2, 30);
        chk(los_alarm, 1'b0, "R5", "release after restarted window");

        // R2: fast reaction to a stall while the alarm is low
        run(0, 8);
        chk(los_alarm, 1'b1, "R2", "alarm within 8 cycles");
        run(2, 60);
        chk(los_alarm, 1'b0, "R3", "recovered before reset test");

        // R6/R7: reset from locked state, calibration withheld
        do_reset(1'b0);
        run(2, 100);
        chk(los_alarm, 1'b1, "R7", "held while calibrating");
        cal_done = 1'b1;
        run(2, 3);
        chk(los_alarm, 1'b0, "R7", "release after cal_done");

        chk(pulse_bad == 0, 1'b1, "R8", "strobe aligned with alarm fall");
        chk(pulses == 6, 1'b1, "R8", "total strobe count");
        finish_run();
    end
endmodule